// File: doc/BRIEF.md
# Indexed Integer Dot-Product Unit

This block is a vector datapath that computes indexed integer dot products. The accumulator vector is divided into lanes, and each lane adds four narrow products to its own value. The first source supplies four consecutive narrow elements for each lane. The second source does not stream lane by lane. Within each 128-bit segment, one group of four elements is chosen by a small immediate index, and that group is shared by every lane of the segment.

Two element sizes are supported. Byte elements feed 32-bit lanes and use a 2-bit group index. Halfword elements feed 64-bit lanes and use a 1-bit index. A mode input chooses whether the narrow elements are sign-extended or zero-extended before they are multiplied. The active operation length is given in bytes. Every destination byte at or above that length is returned as zero.

The unit takes one operation per cycle through a valid/ready handshake. The result is registered and appears one cycle after the operation is accepted. All products come from the operand values presented with the operation, so the result is correct even when the destination also serves as a source.

Top module: `dotp_idx_unit`

## Requirements
- R1: With `esize`=0 (byte mode), 32-bit lane i (bits 32i+31..32i) becomes acc_in lane i plus the sum over k=0..3 of src_n byte 4i+k times src_m byte 16s+4g+k. Here s is the 128-bit segment holding lane i and g is `grp_idx`.
- R2: The group index is resolved separately inside each 128-bit segment. In byte mode both bits of `grp_idx` select one of four 32-bit groups. In halfword mode only `grp_idx[0]` selects one of two 64-bit groups, and `grp_idx[1]` has no effect on the result.
- R3: With `esize`=1 (halfword mode), 64-bit lane j becomes acc_in lane j plus the sum over k=0..3 of src_n halfword 4j+k times src_m halfword 8s+4g+k, where g is `grp_idx[0]`.
- R4: With `sgn_mode`=1 the narrow elements are treated as two's-complement signed values. With `sgn_mode`=0 they are treated as unsigned.
- R5: The accumulation wraps modulo the lane width (2^32 or 2^64). No saturation is applied.
- R6: Every result byte at index `op_len` or above is zero. Only bytes below `op_len` carry lane results.
- R7: `op_len` must be a multiple of 16 no larger than the vector size, or exactly 8 in byte mode. With 8, lanes 0 and 1 use the selected group of the first segment.
- R8: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` rises on the next edge. While `out_valid` is high and `out_ready` is low, `out_acc` and `out_valid` hold.
- R9: `in_ready` equals `!out_valid || out_ready`. After a synchronous reset, `out_valid` is 0 and `out_acc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| esize | input | 1 | 0: byte elements / 32-bit lanes; 1: halfword / 64-bit lanes |
| sgn_mode | input | 1 | 1: signed elements, 0: unsigned |
| grp_idx | input | 2 | Group index within each 128-bit segment |
| op_len | input | $clog2(VEC_BITS/8)+1 | Active length in bytes |
| acc_in | input | VEC_BITS | Accumulator vector before the update |
| src_n | input | VEC_BITS | First source (per-lane elements) |
| src_m | input | VEC_BITS | Second source (indexed groups) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | VEC_BITS | Updated accumulator vector, tail cleared |

## Verification
The reference model is exercised with random operands in both element sizes and both signedness modes, sweeping all four index values. A wrong segment base or a wrong group offset therefore shows up as a lane mismatch in the upper segment. Operands with the top bit set in the narrow elements separate sign extension from zero extension. An all-ones accumulator combined with small products exposes missing wraparound. Halfword runs with `grp_idx[1]` set confirm that the upper index bit is ignored. Lengths of 0, 8, 16 and the full size check the tail clearing. Random `out_ready` stalls and back-to-back issue check that results are held and that acceptance follows the handshake.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int SEG_BITS  = 128;
  localparam int GRP_ELEMS = 4;

  typedef enum logic {
    ESZ_BYTE = 1'b0,
    ESZ_HALF = 1'b1
  } esz_e;
endpackage

// File: rtl/dotp_quad.sv
// Four-term multiply-accumulate for one lane.
module dotp_quad #(
  parameter int EW = 8,
  parameter int AW = 32
) (
  input  logic [4*EW-1:0] n_grp,
  input  logic [4*EW-1:0] m_grp,
  input  logic [AW-1:0]   acc,
  input  logic            sgn,
  output logic [AW-1:0]   sum_o
);
  localparam int PW = 2*EW + 2;
  localparam int SW = PW + 2;

  logic signed [EW:0]   ea [4];
  logic signed [EW:0]   eb [4];
  logic signed [PW-1:0] pr [4];
  logic signed [SW-1:0] total;

  for (genvar k = 0; k < 4; k++) begin : g_prod
    assign ea[k] = {sgn & n_grp[EW*k+EW-1], n_grp[EW*k +: EW]};
    assign eb[k] = {sgn & m_grp[EW*k+EW-1], m_grp[EW*k +: EW]};
    assign pr[k] = ea[k] * eb[k];
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < 4; k++) begin
      total = total + {{(SW-PW){pr[k][PW-1]}}, pr[k]};
    end
    sum_o = acc + {{(AW-SW){total[SW-1]}}, total};
  end

  // R4
  always_comb begin
    if (!sgn) begin
      unsigned_nonneg_chk: assert (!total[SW-1] || $isunknown(total));
    end
  end
endmodule

// File: rtl/dotp_seg.sv
// One 128-bit segment: group select plus byte and halfword lanes.
module dotp_seg
  import dotp_pkg::*;
(
  input  logic [SEG_BITS-1:0] n_seg,
  input  logic [SEG_BITS-1:0] m_seg,
  input  logic [SEG_BITS-1:0] acc_seg,
  input  logic [1:0]          idx,
  input  logic                half,
  input  logic                sgn,
  output logic [SEG_BITS-1:0] res_seg
);
  localparam int BLANES = SEG_BITS / 32;
  localparam int HLANES = SEG_BITS / 64;

  logic [31:0]         m_bgrp;
  logic [63:0]         m_hgrp;
  logic [SEG_BITS-1:0] res_b;
  logic [SEG_BITS-1:0] res_h;

  always_comb begin
    m_bgrp = m_seg[32*idx +: 32];
    m_hgrp = m_seg[64*idx[0] +: 64];
  end

  for (genvar i = 0; i < BLANES; i++) begin : g_blane
    dotp_quad #(.EW(8), .AW(32)) u_q (
      .n_grp (n_seg[32*i +: 32]),
      .m_grp (m_bgrp),
      .acc   (acc_seg[32*i +: 32]),
      .sgn   (sgn),
      .sum_o (res_b[32*i +: 32])
    );
  end

  for (genvar j = 0; j < HLANES; j++) begin : g_hlane
    dotp_quad #(.EW(16), .AW(64)) u_q (
      .n_grp (n_seg[64*j +: 64]),
      .m_grp (m_hgrp),
      .acc   (acc_seg[64*j +: 64]),
      .sgn   (sgn),
      .sum_o (res_h[64*j +: 64])
    );
  end

  assign res_seg = half ? res_h : res_b;
endmodule

// File: rtl/dotp_tail.sv
// Clears every byte at or above the active length.
module dotp_tail #(
  parameter int VB = 32,
  parameter int LW = 6
) (
  input  logic [LW-1:0]   len,
  input  logic [8*VB-1:0] din,
  output logic [8*VB-1:0] dout
);
  for (genvar b = 0; b < VB; b++) begin : g_byte
    assign dout[8*b +: 8] = (LW'(b) < len) ? din[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/dotp_idx_unit.sv
module dotp_idx_unit
  import dotp_pkg::*;
#(
  parameter int VEC_BITS = 256,
  localparam int VB      = VEC_BITS / 8,
  localparam int LW      = $clog2(VB) + 1,
  localparam int NSEG    = VEC_BITS / SEG_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                esize,
  input  logic                sgn_mode,
  input  logic [1:0]          grp_idx,
  input  logic [LW-1:0]       op_len,
  input  logic [VEC_BITS-1:0] acc_in,
  input  logic [VEC_BITS-1:0] src_n,
  input  logic [VEC_BITS-1:0] src_m,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VEC_BITS-1:0] out_acc
);
  esz_e                esz;
  logic [VEC_BITS-1:0] raw_res;
  logic [VEC_BITS-1:0] clr_res;
  logic                take;

  assign esz      = esz_e'(esize);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    dotp_seg u_seg (
      .n_seg   (src_n[SEG_BITS*s +: SEG_BITS]),
      .m_seg   (src_m[SEG_BITS*s +: SEG_BITS]),
      .acc_seg (acc_in[SEG_BITS*s +: SEG_BITS]),
      .idx     (grp_idx),
      .half    (esz == ESZ_HALF),
      .sgn     (sgn_mode),
      .res_seg (raw_res[SEG_BITS*s +: SEG_BITS])
    );
  end

  dotp_tail #(.VB(VB), .LW(LW)) u_tail (
    .len  (op_len),
    .din  (raw_res),
    .dout (clr_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_acc   <= clr_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid && out_acc == '0);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_acc));

  // R6
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> (out_acc >> {$past(op_len), 3'b000}) == '0);

  // R7
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((op_len[3:0] == 4'd0 && op_len <= LW'(VB)) ||
                  (op_len == LW'(8) && esize == 1'b0)));
endmodule

// File: tb/dotp_idx_unit_bench.sv
`timescale 1ns/1ps
module dotp_idx_unit_bench;
  localparam int VBITS = 256;
  localparam int VB    = VBITS / 8;
  localparam int LW    = $clog2(VB) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             esize = 1'b0;
  logic             sgn_mode = 1'b0;
  logic [1:0]       grp_idx = 2'd0;
  logic [LW-1:0]    op_len = LW'(VB);
  logic [VBITS-1:0] acc_in = '0;
  logic [VBITS-1:0] src_n = '0;
  logic [VBITS-1:0] src_m = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VBITS-1:0] out_acc;

  always #2 clk = ~clk;

  dotp_idx_unit #(.VEC_BITS(VBITS)) u_dotp_idx_unit (
    .clk, .rst, .in_valid, .in_ready, .esize, .sgn_mode, .grp_idx,
    .op_len, .acc_in, .src_n, .src_m, .out_valid, .out_ready, .out_acc
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string tag = "R9";

  // driven values for the next edge
  logic             d_rst = 1'b1, d_valid = 1'b0, d_ready = 1'b1;
  logic             d_esz = 1'b0, d_sgn = 1'b0;
  logic [1:0]       d_idx = 2'd0;
  int               d_len = VB;
  logic [VBITS-1:0] d_acc = '0, d_n = '0, d_m = '0;

  // reference state
  bit               m_valid = 1'b0;
  logic [VBITS-1:0] m_data  = '0;

  function automatic longint ext(longint v, int w, bit sg);
    if (sg && v >= (longint'(1) << (w-1))) return v - (longint'(1) << w);
    return v;
  endfunction

  function automatic logic [VBITS-1:0] ref_dot(logic [VBITS-1:0] a, logic [VBITS-1:0] n,
      logic [VBITS-1:0] m, bit half, bit sg, logic [1:0] ix, int len);
    logic [VBITS-1:0] r;
    r = '0;
    if (!half) begin
      for (int i = 0; i < VBITS/32; i++) begin
        longint s = 0;
        int seg = i / 4;
        for (int k = 0; k < 4; k++) begin
          s += ext(longint'(n[(4*i+k)*8 +: 8]), 8, sg) *
               ext(longint'(m[(seg*16 + int'(ix)*4 + k)*8 +: 8]), 8, sg);
        end
        r[32*i +: 32] = a[32*i +: 32] + s[31:0];
      end
    end else begin
      for (int j = 0; j < VBITS/64; j++) begin
        longint s = 0;
        int seg = j / 2;
        for (int k = 0; k < 4; k++) begin
          s += ext(longint'(n[(4*j+k)*16 +: 16]), 16, sg) *
               ext(longint'(m[(seg*8 + int'(ix[0])*4 + k)*16 +: 16]), 16, sg);
        end
        r[64*j +: 64] = a[64*j +: 64] + s;
      end
    end
    for (int b = 0; b < VB; b++) if (b >= len) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [VBITS-1:0] rnd_vec();
    logic [VBITS-1:0] v;
    for (int w = 0; w < VBITS/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  task automatic cycle();
    bit exp_rdy;
    @(negedge clk);
    if (!rst) begin
      exp_rdy = !m_valid || out_ready;
      checks++;
      if (out_valid !== m_valid || in_ready !== exp_rdy) begin
        errors++;
        $display("FAIL %s/R8: valid=%0b ready=%0b expected valid=%0b ready=%0b",
                 tag, out_valid, in_ready, m_valid, exp_rdy);
      end
      if (m_valid) begin
        checks++;
        if (out_acc !== m_data) begin
          errors++;
          $display("FAIL %s: out_acc=%h expected %h", tag, out_acc, m_data);
        end
      end
    end
    rst = d_rst; in_valid = d_valid; out_ready = d_ready;
    esize = d_esz; sgn_mode = d_sgn; grp_idx = d_idx; op_len = LW'(d_len);
    acc_in = d_acc; src_n = d_n; src_m = d_m;
    if (d_rst) begin
      m_valid = 1'b0; m_data = '0;
    end else if (d_valid && (!m_valid || d_ready)) begin
      m_valid = 1'b1;
      m_data  = ref_dot(d_acc, d_n, d_m, d_esz, d_sgn, d_idx, d_len);
    end else if (d_ready) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic issue(bit half, bit sg, logic [1:0] ix, int len);
    d_valid = 1'b1; d_esz = half; d_sgn = sg; d_idx = ix; d_len = len;
    d_acc = rnd_vec(); d_n = rnd_vec(); d_m = rnd_vec();
    cycle();
    d_valid = 1'b0;
  endtask

  initial begin
    repeat (3) cycle();
    d_rst = 1'b0;
    cycle();
    // R9: reset state at the ports
    tag = "R9";
    checks++;
    if (out_valid !== 1'b0 || out_acc !== '0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9: valid=%0b acc=%h ready=%0b expected 0/0/1", out_valid, out_acc, in_ready);
    end

    tag = "R1/R2 byte unsigned";
    for (int r = 0; r < 3; r++)
      for (int ix = 0; ix < 4; ix++) begin issue(0, 0, 2'(ix), VB); cycle(); end

    tag = "R4 byte signed";
    for (int ix = 0; ix < 4; ix++) begin issue(0, 1, 2'(ix), VB); cycle(); end

    tag = "R3/R2 half, index bit 1 ignored";
    for (int sg = 0; sg < 2; sg++)
      for (int ix = 0; ix < 4; ix++) begin issue(1, sg[0], 2'(ix), VB); cycle(); end

    // R5: all-ones accumulator wraps
    tag = "R5";
    d_valid = 1'b1; d_esz = 1'b0; d_sgn = 1'b0; d_idx = 2'd1; d_len = VB;
    d_acc = '1;
    d_n = '0; d_m = '0;
    for (int b = 0; b < VB; b++) d_n[8*b +: 8] = 8'd1;
    for (int b = 0; b < VB; b++) d_m[8*b +: 8] = 8'd1;
    cycle();
    d_valid = 1'b0;
    cycle();
    checks++;
    if (out_acc[31:0] !== 32'd3) begin
      errors++;
      $display("FAIL R5: lane0=%h expected 00000003", out_acc[31:0]);
    end
    issue(1, 1, 2'd0, VB); cycle();

    tag = "R6 tail clear";
    issue(0, 0, 2'd2, 16); cycle();
    issue(1, 1, 2'd1, 16); cycle();
    issue(0, 1, 2'd3, 0);  cycle();

    tag = "R7 short byte op";
    for (int ix = 0; ix < 4; ix++) begin issue(0, ix[0], 2'(ix), 8); cycle(); end

    tag = "R8 back-to-back and stalls";
    for (int r = 0; r < 300; r++) begin
      d_ready = ($urandom % 3) != 0;
      d_valid = ($urandom % 4) != 0;
      d_esz = $urandom; d_sgn = $urandom; d_idx = 2'($urandom);
      d_len = (d_esz == 1'b0 && ($urandom % 5) == 0) ? 8 : 16 * int'($urandom % 3);
      d_acc = rnd_vec(); d_n = rnd_vec(); d_m = rnd_vec();
      cycle();
    end
    d_valid = 1'b0; d_ready = 1'b1;
    repeat (3) cycle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule